// File: doc/BRIEF.md
# Register-Amount Shifter with Carry

This block is a purely combinational shifter for a 32-bit datapath. It takes a data word and a second 32-bit operand that holds the shift distance, and it performs one of four operations on the word: logical left, logical right, arithmetic right or rotate right. Along with the shifted word it produces the carry flag the operation leaves behind, which is the last bit shifted out of the word.

Only the low byte of the distance operand counts, so distances run from 0 to 255. Each operation has its own rule for a distance of zero, for a distance equal to the word width, and for larger distances. A distance of zero leaves both the word and the incoming carry as they are. The block sits in the execute stage of a processor next to the ALU. Its result and carry are used in the same cycle.

Top module: `shc_reg_shifter`

## Requirements
- R1: Only bits 7:0 of `amt_reg_i` set the distance. Bits 31:8 have no effect on either output.
- R2: With a distance of 0, for every operation, `result_o` equals `opnd_i` and `carry_o` equals `carry_i`.
- R3: Logical left by d in 1..31 gives `opnd_i << d`, and the carry is input bit (32 - d).
- R4: Logical left by exactly 32 gives 0 with carry equal to input bit 0. Logical left by 33..255 gives 0 with carry 0.
- R5: Logical right by d in 1..31 gives `opnd_i >> d` with carry equal to input bit (d - 1). By exactly 32 it gives 0 with carry equal to bit 31. By 33..255 it gives 0 with carry 0.
- R6: Arithmetic right by d in 1..31 gives the sign-filled shift with carry equal to bit (d - 1). By 32..255 every result bit equals input bit 31, and the carry equals bit 31.
- R7: Rotate right uses r = d mod 32. When r is not 0, the result is the input rotated right by r and the carry is input bit (r - 1).
- R8: Rotate right by a nonzero distance that is a multiple of 32 leaves the word unchanged and sets the carry to bit 31.
- R9: `kind_i` encodes the operation: 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Word to be shifted |
| amt_reg_i | input | 32 | Register operand; its low byte is the distance |
| kind_i | input | 2 | Operation select (R9 encoding) |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Resulting carry flag |

## Verification
Whenever the inputs change, the assertions check these invariants: the zero-distance pass-through, the all-zero result of logical shifts at the word width and beyond, the uniform sign fill of large arithmetic shifts, the preserved population count of every rotate, and a clear top bit after an in-range logical right shift. Some properties are left to the bench's sweep, which covers every distance byte under all four operations and several data patterns. The sweep shows the exact bit chosen as carry for each distance, the exact rotated and shifted values, and that upper distance bits have no effect.

// File: rtl/shc_pkg.sv
package shc_pkg;

    localparam int unsigned DATA_W_DEF     = 32;
    localparam int unsigned AMT_REG_W_DEF  = 32;
    localparam int unsigned AMT_USED_W_DEF = 8;

    // Operation encoding seen at the port (R9)
    typedef enum logic [1:0] {
        SHK_LSL = 2'b00,
        SHK_LSR = 2'b01,
        SHK_ASR = 2'b10,
        SHK_ROR = 2'b11
    } shift_kind_e;

    // Distance class relative to the word width
    typedef enum logic [1:0] {
        RNG_NONE    = 2'd0,   // distance is zero
        RNG_PARTIAL = 2'd1,   // 1 .. width-1
        RNG_EXACT   = 2'd2,   // exactly width
        RNG_BEYOND  = 2'd3    // above width
    } amt_class_e;

    typedef struct packed {
        amt_class_e cls;
        logic       mod_zero;  // low log2(width) bits are zero
    } amt_info_t;

    // How vacated bit positions are filled in the barrel
    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_WRAP = 2'd2
    } fill_e;

    function automatic fill_e kind_fill(input shift_kind_e k);
        case (k)
            SHK_ASR: return FILL_SIGN;
            SHK_ROR: return FILL_WRAP;
            default: return FILL_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/shc_amount_decode.sv
module shc_amount_decode
    import shc_pkg::*;
#(
    parameter int unsigned DATA_W     = DATA_W_DEF,
    parameter int unsigned AMT_USED_W = AMT_USED_W_DEF,
    localparam int unsigned SH_W      = $clog2(DATA_W)
) (
    input  logic [AMT_USED_W-1:0] amt_i,
    output amt_info_t             info_o,
    output logic [SH_W-1:0]       step_o
);
    localparam logic [AMT_USED_W-1:0] WIDTH_AMT = AMT_USED_W'(DATA_W);

    logic [SH_W-1:0] low_r;
    assign low_r = amt_i[SH_W-1:0];

    always_comb begin
        info_o.mod_zero = (low_r == '0);
        if (amt_i == '0)
            info_o.cls = RNG_NONE;
        else if (amt_i < WIDTH_AMT)
            info_o.cls = RNG_PARTIAL;
        else if (amt_i == WIDTH_AMT)
            info_o.cls = RNG_EXACT;
        else
            info_o.cls = RNG_BEYOND;
    end

    // Barrel runs one short; a final single-bit stage yields the carry.
    assign step_o = low_r - SH_W'(1);

endmodule

// File: rtl/shc_barrel.sv
module shc_barrel
    import shc_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEF,
    localparam int unsigned SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [SH_W-1:0]   step_i,
    input  fill_e             fill_i,
    input  logic              reverse_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o
);
    logic              sign_b;
    logic [DATA_W-1:0] pre;
    logic [DATA_W-1:0] stg [SH_W+1];
    logic [DATA_W-1:0] last;
    logic              last_fill;

    assign sign_b = data_i[DATA_W-1];

    // Left shifts run as right shifts on a bit-reversed word.
    for (genvar i = 0; i < DATA_W; i++) begin : g_pre
        assign pre[i] = reverse_i ? data_i[DATA_W-1-i] : data_i[i];
    end

    assign stg[0] = pre;

    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        localparam int unsigned D = 1 << s;
        logic [D-1:0] fill_v;
        assign fill_v = (fill_i == FILL_WRAP) ? stg[s][D-1:0] :
                        (fill_i == FILL_SIGN) ? {D{sign_b}}   : '0;
        assign stg[s+1] = step_i[s] ? {fill_v, stg[s][DATA_W-1:D]} : stg[s];
    end

    assign last_fill = (fill_i == FILL_WRAP) ? stg[SH_W][0] :
                       (fill_i == FILL_SIGN) ? sign_b       : 1'b0;
    assign last      = {last_fill, stg[SH_W][DATA_W-1:1]};
    assign carry_o   = stg[SH_W][0];

    for (genvar i = 0; i < DATA_W; i++) begin : g_post
        assign res_o[i] = reverse_i ? last[DATA_W-1-i] : last[i];
    end

endmodule

// File: rtl/shc_edge_select.sv
module shc_edge_select
    import shc_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEF
) (
    input  shift_kind_e       kind_i,
    input  amt_info_t         info_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              carry_i,
    input  logic [DATA_W-1:0] brl_res_i,
    input  logic              brl_carry_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o
);
    logic msb;
    assign msb = data_i[DATA_W-1];

    always_comb begin
        res_o   = brl_res_i;
        carry_o = brl_carry_i;
        if (info_i.cls == RNG_NONE) begin
            res_o   = data_i;
            carry_o = carry_i;
        end else begin
            case (kind_i)
                SHK_LSL: if (info_i.cls != RNG_PARTIAL) begin
                    res_o   = '0;
                    carry_o = (info_i.cls == RNG_EXACT) ? data_i[0] : 1'b0;
                end
                SHK_LSR: if (info_i.cls != RNG_PARTIAL) begin
                    res_o   = '0;
                    carry_o = (info_i.cls == RNG_EXACT) ? msb : 1'b0;
                end
                SHK_ASR: if (info_i.cls != RNG_PARTIAL) begin
                    res_o   = {DATA_W{msb}};
                    carry_o = msb;
                end
                default: if (info_i.mod_zero) begin
                    res_o   = data_i;
                    carry_o = msb;
                end
            endcase
        end
    end

    // R4 R5: logical shifts at or past the width clear the word
    always_comb begin
        if ((kind_i == SHK_LSL || kind_i == SHK_LSR) &&
            (info_i.cls == RNG_EXACT || info_i.cls == RNG_BEYOND)) begin
            logical_flush_chk: assert (res_o == '0)
                else $error("logical shift past width left bits set");
        end
    end

endmodule

// File: rtl/shc_reg_shifter.sv
module shc_reg_shifter
    import shc_pkg::*;
#(
    parameter int unsigned DATA_W     = DATA_W_DEF,
    parameter int unsigned AMT_REG_W  = AMT_REG_W_DEF,
    parameter int unsigned AMT_USED_W = AMT_USED_W_DEF,
    localparam int unsigned SH_W      = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]    opnd_i,
    input  logic [AMT_REG_W-1:0] amt_reg_i,
    input  logic [1:0]           kind_i,
    input  logic                 carry_i,
    output logic [DATA_W-1:0]    result_o,
    output logic                 carry_o
);
    shift_kind_e           kind;
    amt_info_t             info;
    logic [SH_W-1:0]       step;
    logic [DATA_W-1:0]     brl_res;
    logic                  brl_carry;
    logic [AMT_USED_W-1:0] amt;
    logic                  unused_amt_hi;

    // R1: only the low byte forms the distance
    assign amt           = amt_reg_i[AMT_USED_W-1:0];
    assign unused_amt_hi = ^amt_reg_i[AMT_REG_W-1:AMT_USED_W];
    // R9: port encoding maps directly onto the enum
    assign kind          = shift_kind_e'(kind_i);

    shc_amount_decode #(.DATA_W(DATA_W), .AMT_USED_W(AMT_USED_W)) dec_i (
        .amt_i  (amt),
        .info_o (info),
        .step_o (step)
    );

    shc_barrel #(.DATA_W(DATA_W)) brl_i (
        .data_i    (opnd_i),
        .step_i    (step),
        .fill_i    (kind_fill(kind)),
        .reverse_i (kind == SHK_LSL),
        .res_o     (brl_res),
        .carry_o   (brl_carry)
    );

    shc_edge_select #(.DATA_W(DATA_W)) sel_i (
        .kind_i      (kind),
        .info_i      (info),
        .data_i      (opnd_i),
        .carry_i     (carry_i),
        .brl_res_i   (brl_res),
        .brl_carry_i (brl_carry),
        .res_o       (result_o),
        .carry_o     (carry_o)
    );

    always_comb begin
        // R2
        if (amt == '0) begin
            zero_amt_chk: assert (result_o == opnd_i && carry_o == carry_i)
                else $error("zero distance altered word or carry");
        end
        // R7 R8
        if (kind_i == 2'b11) begin
            rotate_pop_chk: assert ($countones(result_o) == $countones(opnd_i))
                else $error("rotate changed population count");
        end
        // R6
        if (kind_i == 2'b10 && amt >= AMT_USED_W'(DATA_W)) begin
            asr_fill_chk: assert ((result_o == '0 || result_o == '1) &&
                                  result_o[0] == opnd_i[DATA_W-1] &&
                                  carry_o == opnd_i[DATA_W-1])
                else $error("large arithmetic shift not sign filled");
        end
        // R5
        if (kind_i == 2'b01 && amt != '0) begin
            lsr_msb_chk: assert (result_o[DATA_W-1] == 1'b0)
                else $error("logical right shift kept top bit");
        end
    end

endmodule

// File: tb/shc_reg_shifter_tb_top.sv
module shc_reg_shifter_tb_top;

    logic        clk = 1'b0;
    logic [31:0] opnd;
    logic [31:0] amt_reg;
    logic [1:0]  kind;
    logic        cin;
    logic [31:0] res;
    logic        cout;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    shc_reg_shifter dut_i (
        .opnd_i    (opnd),
        .amt_reg_i (amt_reg),
        .kind_i    (kind),
        .carry_i   (cin),
        .result_o  (res),
        .carry_o   (cout)
    );

    // Reference computed from the requirement text (R9 encoding for k)
    function automatic void model(input logic [1:0] k, input logic [31:0] x,
                                  input int d, input logic ci,
                                  output logic [31:0] r, output logic c);
        int rr;
        rr = d % 32;
        r = x; c = ci;
        if (d != 0) begin
            case (k)
                2'b00: begin
                    if (d < 32)       begin r = x << d; c = x[32-d]; end
                    else if (d == 32) begin r = '0; c = x[0]; end
                    else              begin r = '0; c = 1'b0; end
                end
                2'b01: begin
                    if (d < 32)       begin r = x >> d; c = x[d-1]; end
                    else if (d == 32) begin r = '0; c = x[31]; end
                    else              begin r = '0; c = 1'b0; end
                end
                2'b10: begin
                    if (d < 32) begin r = 32'($signed(x) >>> d); c = x[d-1]; end
                    else        begin r = {32{x[31]}}; c = x[31]; end
                end
                default: begin
                    if (rr == 0) begin r = x; c = x[31]; end
                    else begin r = (x >> rr) | (x << (32 - rr)); c = x[rr-1]; end
                end
            endcase
        end
    endfunction

    function automatic string req_tag(input logic [1:0] k, input int d);
        if (d == 0) return "R2";
        case (k)
            2'b00:   return (d < 32) ? "R3" : "R4";
            2'b01:   return "R5";
            2'b10:   return "R6";
            default: return (d % 32 == 0) ? "R8" : "R7";
        endcase
    endfunction

    task automatic apply_check(input logic [1:0] k, input logic [31:0] x,
                               input logic [31:0] areg, input logic ci,
                               input string tag);
        logic [31:0] er;
        logic        ec;
        @(negedge clk);
        kind = k; opnd = x; amt_reg = areg; cin = ci;
        #1;
        model(k, x, int'(areg[7:0]), ci, er, ec);
        n_checks++;
        if (res !== er || cout !== ec) begin
            n_fail++;
            $display("FAIL %s kind=%0d amt=%08h opnd=%08h: actual res=%08h c=%0b expected res=%08h c=%0b",
                     tag, k, areg, x, res, cout, er, ec);
        end
    endtask

    logic [31:0] pats [7] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hDEAD_BEEF,
                              32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_0000,
                              32'hA5A5_5A5A};

    initial begin
        opnd = '0; amt_reg = '0; kind = 2'b00; cin = 1'b0;
        repeat (2) @(posedge clk);
        // Initial state: all-zero inputs pass through (R2)
        apply_check(2'b00, 32'h0, 32'h0, 1'b0, "R2");

        // Full sweep: every distance byte, all four kinds (R9), varied data
        for (int p = 0; p < 7; p++) begin
            for (int k = 0; k < 4; k++) begin
                for (int d = 0; d < 256; d++) begin
                    apply_check(2'(k), pats[p], 32'(d), logic'((d ^ p) & 1),
                                req_tag(2'(k), d));
                end
            end
        end

        // R1: upper operand bits set must not change anything
        for (int k = 0; k < 4; k++) begin
            for (int d = 0; d < 256; d += 7) begin
                apply_check(2'(k), 32'hC3A5_0F81, {24'hFFFF_FF ^ 24'(d * 97), 8'(d)},
                            logic'(d & 1), "R1");
            end
        end

        // Boundary distances with each carry-in value
        for (int ci = 0; ci < 2; ci++) begin
            apply_check(2'b00, 32'h0000_0001, 32'd32,  logic'(ci), "R4");
            apply_check(2'b00, 32'hFFFF_FFFF, 32'd33,  logic'(ci), "R4");
            apply_check(2'b01, 32'h8000_0000, 32'd32,  logic'(ci), "R5");
            apply_check(2'b10, 32'h8000_0000, 32'd255, logic'(ci), "R6");
            apply_check(2'b11, 32'h8000_0000, 32'd64,  logic'(ci), "R8");
            apply_check(2'b11, 32'h0000_0001, 32'd33,  logic'(ci), "R7");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule